// File: doc/BRIEF.md
# Error-Rate Driven Delay Tuner

This controller sets, at run time, the nominal delay of a speculative pipeline stage. It watches the stream of per-token timing-error responses and moves a binary delay codeword so that the error probability it observes settles near a programmable target. The target is usually chosen between 20% and 35%. The stage's average delay is d = δ + p·Δ, where p is the chance that a token's logic outlasts δ. Because the best p does not depend on the spread of the delays, holding p at a fixed target is enough to keep d near its minimum.

Responses are grouped into windows of `WIN` valid tokens. When a window closes, the error count is compared against a band made of the target count plus or minus a hysteresis count. Too many errors lengthen δ by one delay unit. Too few errors shorten it by one unit. A count inside the band leaves δ unchanged.

The cycle bound is held at the worst-case delay K = δ + Δ. The resiliency window Δ is recomputed from every new δ and is capped at half of K. The delay element that receives the codeword is modelled here as a down-counter. A launch pulse makes it busy for exactly δ cycles.

Top module: `err_rate_tuner`

## Requirements
- R1: While `rst_n` is low and after its release, `delay_code` equals `DMAX` (64-unit bound K, default 60), `margin_code` equals min(K−DMAX, K/2), `tuned` is 0 and `dl_busy` is 0.
- R2: A window closes on the clock edge that samples its `WIN`-th token with `tok_valid` high. `delay_code` changes on that edge and on no other.
- R3: If a closing window's error count (including the closing token) is greater than `err_target + err_hyst`, `delay_code` rises by one.
- R4: If the error count plus `err_hyst` is less than `err_target`, `delay_code` falls by one.
- R5: Any other count keeps `delay_code` unchanged, including counts exactly at either band edge.
- R6: `delay_code` saturates at `DMAX` and at `DMIN` and never wraps.
- R7: `margin_code` always equals min(K − `delay_code`, K/2). It is updated on the same edge as `delay_code`, so `delay_code + margin_code` never exceeds K.
- R8: `tuned` rises when a window closes as the third consecutive in-band window. It stays high while windows stay in band. It drops on the closing edge of any out-of-band window.
- R9: A `dl_start` pulse sampled while the delay counter is idle keeps `dl_busy` high for exactly `delay_code` cycles. A `dl_start` sampled while busy has no effect on when `dl_busy` falls.
- R10: `tok_err` has no effect when `tok_valid` is low. Such cycles add neither tokens nor errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | A token response is present this cycle |
| tok_err | input | 1 | The present token raised a timing error |
| err_target | input | CNTW | Target error count per window |
| err_hyst | input | CNTW | Half-width of the in-band region, in errors |
| dl_start | input | 1 | Launch the modelled delay element |
| delay_code | output | CW | Nominal delay codeword δ |
| margin_code | output | MW | Resiliency window Δ in delay units |
| tuned | output | 1 | Error rate has held in band for three windows |
| dl_busy | output | 1 | Modelled delay element is counting |

## Verification
The tuner is driven with windows whose error counts sit just above, just below, exactly on and well outside the band. This separates the increment path, the decrement path and the hold path, including the off-by-one choices at both band edges. Long runs of error-free windows and of all-error windows push the codeword against both rails, which exposes any wrap or missing clamp of Δ. Windows interleaved with invalid cycles that carry an asserted error flag show whether invalid cycles leak into the token or error counts. Sequences of two and three in-band windows, followed by one out-of-band window, pin down when `tuned` rises and falls. Launches of the delay counter, with a second launch issued mid-count, show that the busy time equals the current codeword.

// File: rtl/err_rate_tuner.sv
module err_rate_tuner #(
  parameter int CW     = 6,
  parameter int K      = 64,
  parameter int DMIN   = 4,
  parameter int DMAX   = 60,
  parameter int WIN    = 16,
  parameter int STREAK = 3,
  parameter int CNTW   = $clog2(WIN + 1),
  parameter int MW     = $clog2(K / 2 + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tok_valid,
  input  logic            tok_err,
  input  logic [CNTW-1:0] err_target,
  input  logic [CNTW-1:0] err_hyst,
  input  logic            dl_start,
  output logic [CW-1:0]   delay_code,
  output logic [MW-1:0]   margin_code,
  output logic            tuned,
  output logic            dl_busy
);
  localparam int HALF = K / 2;
  localparam int SW   = $clog2(STREAK + 1);

  function automatic logic [MW-1:0] margin_of(input logic [CW-1:0] d);
    int r;
    r = K - int'(d);
    if (r > HALF) r = HALF;
    if (r < 0) r = 0;
    return MW'(r);
  endfunction

  logic [CNTW-1:0] tok_cnt, err_cnt;
  logic [SW-1:0]   streak;
  logic [CW-1:0]   dl_cnt, delay_nxt;

  wire            win_last = tok_valid && (tok_cnt == CNTW'(WIN - 1));
  wire [CNTW:0]   errs     = {1'b0, err_cnt} + {{CNTW{1'b0}}, tok_err};
  wire [CNTW:0]   hi_lim   = {1'b0, err_target} + {1'b0, err_hyst};
  wire            too_many = errs > hi_lim;
  wire            too_few  = (errs + {1'b0, err_hyst}) < {1'b0, err_target};
  wire            in_band  = !too_many && !too_few;

  always_comb begin
    delay_nxt = delay_code;
    if (too_many && delay_code != CW'(DMAX)) delay_nxt = delay_code + 1'b1;
    else if (too_few && delay_code != CW'(DMIN)) delay_nxt = delay_code - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tok_cnt <= '0;
      err_cnt <= '0;
    end else if (win_last) begin
      tok_cnt <= '0;
      err_cnt <= '0;
    end else if (tok_valid) begin
      tok_cnt <= tok_cnt + 1'b1;
      err_cnt <= errs[CNTW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delay_code  <= CW'(DMAX);
      margin_code <= margin_of(CW'(DMAX));
    end else if (win_last) begin
      delay_code  <= delay_nxt;
      margin_code <= margin_of(delay_nxt);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      streak <= '0;
      tuned  <= 1'b0;
    end else if (win_last) begin
      if (!in_band) begin
        streak <= '0;
        tuned  <= 1'b0;
      end else if (streak != SW'(STREAK)) begin
        streak <= streak + 1'b1;
        tuned  <= (streak == SW'(STREAK - 1));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dl_cnt <= '0;
    else if (dl_cnt != '0) dl_cnt <= dl_cnt - 1'b1;
    else if (dl_start) dl_cnt <= delay_code;
  end

  assign dl_busy = dl_cnt != '0;

  // R6
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    delay_code >= CW'(DMIN) && delay_code <= CW'(DMAX));

  // R7
  bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(delay_code) + int'(margin_code) <= K) && (int'(margin_code) <= HALF));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(delay_code) |-> $past(win_last));

  // R8
  tuned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tuned) |-> $past(win_last));

  // R9
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dl_busy) |-> $past(dl_start));
endmodule

// File: tb/sim_err_rate_tuner.sv
module sim_err_rate_tuner;
  localparam int CW = 6, K = 64, DMIN = 4, DMAX = 60, WIN = 16, CNTW = 5, MW = 6;

  logic clk = 0, rst_n = 0;
  logic tok_valid = 0, tok_err = 0, dl_start = 0;
  logic [CNTW-1:0] err_target = 5'd4, err_hyst = 5'd1;
  logic [CW-1:0] delay_code;
  logic [MW-1:0] margin_code;
  logic tuned, dl_busy;

  always #4 clk = ~clk;

  err_rate_tuner u0 (.clk, .rst_n, .tok_valid, .tok_err, .err_target, .err_hyst,
                     .dl_start, .delay_code, .margin_code, .tuned, .dl_busy);

  int checks = 0, errors = 0;
  int m_delta, m_tok, m_err, m_streak, m_done, m_cnt;

  function automatic int marg(int d);
    return (K - d > K / 2) ? K / 2 : K - d;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_delta = DMAX; m_tok = 0; m_err = 0; m_streak = 0; m_done = 0; m_cnt = 0;
    end else begin
      if (m_cnt > 0) m_cnt--;
      else if (dl_start) m_cnt = m_delta;
      // R10: only valid tokens count
      if (tok_valid) begin
        int e;
        e = m_err + int'(tok_err);
        if (m_tok == WIN - 1) begin
          if (e > int'(err_target) + int'(err_hyst)) begin
            if (m_delta < DMAX) m_delta++;
            m_streak = 0; m_done = 0;
          end else if (e + int'(err_hyst) < int'(err_target)) begin
            if (m_delta > DMIN) m_delta--;
            m_streak = 0; m_done = 0;
          end else begin
            if (m_streak < 3) m_streak++;
            if (m_streak == 3) m_done = 1;
          end
          m_tok = 0; m_err = 0;
        end else begin
          m_tok++; m_err = e;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R3", int'(delay_code), m_delta);
    chk("R7", int'(margin_code), marg(m_delta));
    chk("R8", int'(tuned), m_done);
    chk("R9", int'(dl_busy), int'(m_cnt > 0));
  end

  task automatic step(bit v, bit e, bit s);
    tok_valid = v; tok_err = e; dl_start = s;
    @(negedge clk);
  endtask

  task automatic win(int nerr, bit gaps);
    for (int i = 0; i < WIN; i++) begin
      if (gaps && (i % 3 == 0)) step(0, 1, (i % 5) == 0);
      step(1, i < nerr, (i % 7) == 0);
    end
    tok_valid = 0; tok_err = 0; dl_start = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1", int'(delay_code), DMAX);
    chk("R1", int'(margin_code), K - DMAX);
    chk("R1", int'(tuned), 0);
    chk("R1", int'(dl_busy), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", int'(delay_code), DMAX);
    win(10, 0);
    chk("R6", int'(delay_code), DMAX);
    // R2: fifteen tokens leave delay alone
    for (int i = 0; i < WIN - 1; i++) step(1, 0, 0);
    chk("R2", int'(delay_code), DMAX);
    step(1, 0, 0);
    chk("R4", int'(delay_code), DMAX - 1);
    win(2, 0);
    chk("R4", int'(delay_code), DMAX - 2);
    win(3, 1);
    chk("R5", int'(delay_code), DMAX - 2);
    win(5, 0);
    chk("R5", int'(delay_code), DMAX - 2);
    chk("R8", int'(tuned), 0);
    win(4, 1);
    chk("R10", int'(delay_code), DMAX - 2);
    chk("R8", int'(tuned), 1);
    win(4, 0);
    chk("R8", int'(tuned), 1);
    win(6, 0);
    chk("R3", int'(delay_code), DMAX - 1);
    chk("R8", int'(tuned), 0);
    for (int w = 0; w < 60; w++) win(0, 1);
    chk("R6", int'(delay_code), DMIN);
    chk("R7", int'(margin_code), K / 2);
    win(16, 0);
    chk("R3", int'(delay_code), DMIN + 1);
    for (int w = 0; w < 30; w++) win(9, 0);
    chk("R7", int'(margin_code), K - (DMIN + 31));
    begin
      int n;
      for (int i = 0; i < 100 && dl_busy; i++) step(0, 0, 0);
      step(0, 0, 1);
      n = 0;
      while (dl_busy && n < 200) begin
        n++;
        step(0, 0, n == 2);
      end
      chk("R9", n, DMIN + 31);
    end
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule